// File: doc/BRIEF.md
# Dual-Page Two-Wire Register Slave

This block is a serial slave on a two-wire bus (one clock line, one data line). It answers two fixed 7-bit device addresses. Each address opens its own 256-byte register page.

- The identity page is a read-only table of module description bytes.
- The diagnostic page holds monitor values. A window of it can also be written by the host.

The slave supports:

- random-address writes;
- random reads (an address write followed by a repeated START and a read);
- current-address reads;
- sequential reads that run on for as long as the master acknowledges.

Both bus lines are oversampled by a much faster system clock. Each line passes through a two-flop synchronizer and a run-length glitch filter before START, STOP and clock edges are decoded. This lets the slave follow a bus clock of up to 400 kHz and faster. The slave reaches both pages through byte-wide ports:

- Reads are combinational from the page read data inputs, addressed by the page pointer.
- Writes leave the block as a one-cycle registered strobe with its own address and data.

The data line is open-drain. The block only tells the pad when to pull low.

Top module: `twowire_dual_slave`

## Requirements
- R1: A device byte carrying the 7-bit address 0x50 (wire bytes 0xA0 write, 0xA1 read) is acknowledged and selects the identity page.
- R2: A device byte carrying the 7-bit address 0x51 (wire bytes 0xA2 write, 0xA3 read) is acknowledged and selects the diagnostic page.
- R3: Any other device address is not acknowledged. The slave then leaves SDA released and ignores the bus, including a repeated START, until a STOP. Its page pointers are unchanged by such a transaction.
- R4: In a write, the first byte after the device byte loads the page pointer. Every later data byte advances the pointer by one. In a read, each byte sent advances the pointer, and the next byte follows while the master acknowledges.
- R5: The pointer wraps from 255 to 0 and stays within the same page.
- R6: Each page keeps its own pointer. A current-address read (no address byte) starts at the pointer of the page it addresses.
- R7: Data bytes written to the identity page are acknowledged and discarded, and the pointer still advances.
- R8: A data byte written to the diagnostic page is stored only at byte addresses 128 to 247. Bytes aimed at 0..127 or 248..255 are acknowledged and discarded.
- R9: A master NACK ends a read. The slave releases SDA and does not drive it again until a STOP.
- R10: Pulses on SCL or SDA that last fewer than HOLD system clocks (default 4) are ignored: they create no clock edge, START or STOP.
- R11: During reset SDA is released and no write strobe is issued. A write strobe lasts exactly one system clock.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| id_addr | output | 8 | Identity page read address (its pointer) |
| id_rdata | input | 8 | Identity page read data for id_addr |
| diag_addr | output | 8 | Diagnostic page read address (its pointer) |
| diag_rdata | input | 8 | Diagnostic page read data for diag_addr |
| diag_we | output | 1 | One-cycle diagnostic page write strobe |
| diag_waddr | output | 8 | Diagnostic page write address |
| diag_wdata | output | 8 | Diagnostic page write data |

## Verification
Two things happen on the same system clock edge:

- the write strobe toward the diagnostic page;
- the advance of that page's pointer, which also drives the read address.

If the strobe used the pointer after its advance, every byte would land one address too high. The bench provokes this with bursts that cross both edges of the writable window (126..128 and 246..248) and a burst that wraps at 255. It judges the result in two ways: by reading every touched byte back against its own behavioural page image, and by a property that ties the strobe address to the pointer minus one in the strobe cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tw_state_e;

    typedef struct packed {
        tw_state_e   st;
        logic [7:0]  sh;
        logic [3:0]  cnt;
        logic        page;
        logic        rw;
        logic        oe;
        logic        mack;
        logic        we;
        logic [7:0]  waddr;
        logic [7:0]  wdata;
    } tw_regs_t;

    function automatic logic tw_in_window(input logic [7:0] a,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(HOLD + 1);

    logic [1:0]    sync_d, sync_q;
    logic [CW-1:0] run_d,  run_q;
    logic          out_d,  out_q;

    always_comb begin
        sync_d = {sync_q[0], din};
        run_d  = run_q;
        out_d  = out_q;
        if (sync_q[1] == out_q) begin
            run_d = '0;
        end else if (run_q == CW'(HOLD - 1)) begin
            out_d = sync_q[1];
            run_d = '0;
        end else begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            run_q  <= run_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign ev_rise  =  scl & ~scl_q;
    assign ev_fall  = ~scl &  scl_q;
    assign ev_start =  scl &  scl_q &  sda_q & ~sda;
    assign ev_stop  =  scl &  scl_q & ~sda_q &  sda;
endmodule

// File: rtl/tw_page_ptrs.sv
module tw_page_ptrs #(
    parameter int NPAGES = 2,
    parameter int AW     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PW-1:0]               sel,
    input  logic                        load,
    input  logic [AW-1:0]               load_val,
    input  logic                        inc,
    output logic [NPAGES-1:0][AW-1:0]   ptr
);
    localparam int PW = (NPAGES > 1) ? $clog2(NPAGES) : 1;

    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        logic [AW-1:0] ptr_d, ptr_q;
        logic          hit;

        assign hit = (sel == PW'(g));

        always_comb begin
            ptr_d = ptr_q;
            if (hit && load) begin
                ptr_d = load_val;
            end else if (hit && inc) begin
                ptr_d = ptr_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ptr_q <= '0;
            else        ptr_q <= ptr_d;
        end

        assign ptr[g] = ptr_q;
    end
endmodule

// File: rtl/twowire_dual_slave.sv
module twowire_dual_slave #(
    parameter logic [6:0] ID_DEV   = 7'h50,
    parameter logic [6:0] DIAG_DEV = 7'h51,
    parameter logic [7:0] WR_LO    = 8'd128,
    parameter logic [7:0] WR_HI    = 8'd247,
    parameter int         HOLD     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] id_addr,
    input  logic [7:0] id_rdata,
    output logic [7:0] diag_addr,
    input  logic [7:0] diag_rdata,
    output logic       diag_we,
    output logic [7:0] diag_waddr,
    output logic [7:0] diag_wdata
);
    import tw_pkg::*;

    localparam int NPAGES = 2;
    localparam int AW     = 8;
    localparam int BITS   = 8;

    // Line conditioning
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    tw_line_filter #(.HOLD(HOLD)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
    );
    tw_line_filter #(.HOLD(HOLD)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
    );

    tw_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_rise(ev_rise), .ev_fall(ev_fall)
    );

    // Page pointers
    tw_regs_t                   r_d, r_q;
    logic                       ptr_load, ptr_inc;
    logic [AW-1:0]              ptr_val;
    logic [NPAGES-1:0][AW-1:0]  ptrs;
    logic [AW-1:0]              cur_ptr;
    logic [7:0]                 rd_byte;

    tw_page_ptrs #(.NPAGES(NPAGES), .AW(AW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .sel(r_q.page),
        .load(ptr_load), .load_val(ptr_val), .inc(ptr_inc), .ptr(ptrs)
    );

    assign cur_ptr = ptrs[r_q.page];
    assign rd_byte = r_q.page ? diag_rdata : id_rdata;

    // Protocol next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        ptr_val  = r_q.sh;

        if (ev_stop) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (ev_start && r_q.st != ST_SKIP) begin
            r_d.st  = ST_DEV;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_DEV: begin
                    if (ev_rise && r_q.cnt < 4'(BITS)) begin
                        r_d.sh  = {r_q.sh[6:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (ev_fall && r_q.cnt == 4'(BITS)) begin
                        if (r_q.sh[7:1] == ID_DEV || r_q.sh[7:1] == DIAG_DEV) begin
                            r_d.page = (r_q.sh[7:1] == DIAG_DEV);
                            r_d.rw   = r_q.sh[0];
                            r_d.oe   = 1'b1;
                            r_d.st   = ST_DEV_ACK;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.st = ST_RD;
                            r_d.sh = rd_byte;
                            r_d.oe = ~rd_byte[7];
                        end else begin
                            r_d.st = ST_ADR;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                ST_ADR: begin
                    if (ev_rise && r_q.cnt < 4'(BITS)) begin
                        r_d.sh  = {r_q.sh[6:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (ev_fall && r_q.cnt == 4'(BITS)) begin
                        ptr_load = 1'b1;
                        r_d.oe   = 1'b1;
                        r_d.st   = ST_ADR_ACK;
                    end
                end
                ST_ADR_ACK, ST_WR_ACK: begin
                    if (ev_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WR;
                    end
                end
                ST_WR: begin
                    if (ev_rise && r_q.cnt < 4'(BITS)) begin
                        r_d.sh  = {r_q.sh[6:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (ev_fall && r_q.cnt == 4'(BITS)) begin
                        ptr_inc = 1'b1;
                        if (r_q.page && tw_in_window(cur_ptr, WR_LO, WR_HI)) begin
                            r_d.we    = 1'b1;
                            r_d.waddr = cur_ptr;
                            r_d.wdata = r_q.sh;
                        end
                        r_d.oe = 1'b1;
                        r_d.st = ST_WR_ACK;
                    end
                end
                ST_RD: begin
                    if (ev_fall) begin
                        if (r_q.cnt == 4'(BITS - 1)) begin
                            r_d.oe  = 1'b0;
                            ptr_inc = 1'b1;
                            r_d.st  = ST_RD_ACK;
                        end else begin
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.oe  = ~r_q.sh[6];
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_f;
                    end else if (ev_fall) begin
                        if (r_q.mack) begin
                            r_d.st  = ST_RD;
                            r_d.cnt = '0;
                            r_d.sh  = rd_byte;
                            r_d.oe  = ~rd_byte[7];
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe     = r_q.oe;
    assign id_addr    = ptrs[0];
    assign diag_addr  = ptrs[1];
    assign diag_we    = r_q.we;
    assign diag_waddr = r_q.waddr;
    assign diag_wdata = r_q.wdata;
endmodule

// File: rtl/tw_dual_slave_chk.sv
module tw_dual_slave_chk #(
    parameter logic [7:0] LO = 8'd128,
    parameter logic [7:0] HI = 8'd247
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       diag_we,
    input logic [7:0] diag_addr,
    input logic [7:0] diag_waddr
);
    // R8: stores only land inside the writable window
    a_r8_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        diag_we |-> (diag_waddr >= LO && diag_waddr <= HI));

    // R4: the strobe uses the pointer value from before its advance
    a_r4_ptr_moves_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        diag_we |-> (diag_addr == 8'(diag_waddr + 8'd1)));

    // R11: strobe is a single cycle
    a_r11_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        diag_we |=> !diag_we);

    // R12: drive begins only with SCL low
    a_r12_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R12: drive ends only with SCL low
    a_r12_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i);
endmodule

bind twowire_dual_slave tw_dual_slave_chk #(.LO(WR_LO), .HI(WR_HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .diag_we(diag_we), .diag_addr(diag_addr), .diag_waddr(diag_waddr)
);

// File: tb/tb_twowire_dual_slave.sv
module tb_twowire_dual_slave;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       sda_oe;
    logic [7:0] id_addr, id_rdata, diag_addr, diag_rdata;
    logic       diag_we;
    logic [7:0] diag_waddr, diag_wdata;
    logic       sda_line;

    logic [7:0] id_mem   [256];
    logic [7:0] diag_mem [256];
    logic [7:0] m_diag   [256];
    int         m_ptr    [2];
    logic [7:0] wq[$];

    int total = 0, bad = 0, cyc = 0;
    int quiet_viol = 0, r12_viol = 0;
    logic quiet = 1'b0, prev_oe = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line   = sda_m & ~sda_oe;
    assign id_rdata   = id_mem[id_addr];
    assign diag_rdata = diag_mem[diag_addr];

    always @(posedge clk) if (diag_we) diag_mem[diag_waddr] <= diag_wdata;

    twowire_dual_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .id_addr(id_addr), .id_rdata(id_rdata),
        .diag_addr(diag_addr), .diag_rdata(diag_rdata),
        .diag_we(diag_we), .diag_waddr(diag_waddr), .diag_wdata(diag_wdata)
    );

    // Per-clock comparison against the behavioural expectations
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (quiet && sda_oe) quiet_viol++;
            if (sda_oe != prev_oe && scl_m) r12_viol++;
        end
        prev_oe = sda_oe;
        if (cyc == 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung (actual=%0d cycles expected<150000)", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        cycles(Q); sda_m = 1'b1; cycles(Q); scl_m = 1'b1;
        cycles(Q); sda_m = 1'b0; cycles(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        cycles(Q); sda_m = 1'b0; cycles(Q); scl_m = 1'b1;
        cycles(Q); sda_m = 1'b1; cycles(Q);
    endtask

    task automatic send_bit(input logic b);
        cycles(Q); sda_m = b; cycles(Q); scl_m = 1'b1; cycles(2*Q); scl_m = 1'b0;
    endtask

    task automatic send_bit_glitch(input logic b);
        cycles(3); scl_m = 1'b1; cycles(2); scl_m = 1'b0; cycles(Q-5);
        sda_m = b; cycles(Q); scl_m = 1'b1; cycles(Q);
        if (b) begin sda_m = 1'b0; cycles(2); sda_m = 1'b1; cycles(Q-2); end
        else   cycles(Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        cycles(Q); sda_m = 1'b1; cycles(Q); scl_m = 1'b1;
        cycles(Q); b = sda_line; cycles(Q); scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~ack);
    endtask

    function automatic logic writable(input int a);
        return (a >= 128) && (a <= 247);
    endfunction

    function automatic logic [7:0] dev_byte(input int page, input logic rd);
        return {6'b101000, page[0], rd};
    endfunction

    // Address phase plus data bytes from wq; updates the model
    task automatic t_write(input int page, input logic [7:0] a, input string tag);
        logic ack;
        bus_start;
        write_byte(dev_byte(page, 1'b0), ack); chk(ack, {tag, " device ack"}, ack, 1);
        write_byte(a, ack);                    chk(ack, {tag, " address ack"}, ack, 1);
        m_ptr[page] = a;
        foreach (wq[i]) begin
            write_byte(wq[i], ack);            chk(ack, {tag, " data ack"}, ack, 1);
            if (page == 1 && writable(m_ptr[page])) m_diag[m_ptr[page]] = wq[i];
            m_ptr[page] = (m_ptr[page] + 1) % 256;
        end
        bus_stop;
    endtask

    task automatic rd_body(input int page, input int n, input string tag);
        logic ack;
        logic [7:0] v, e;
        write_byte(dev_byte(page, 1'b1), ack); chk(ack, {tag, " read device ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(v, i < n - 1);
            e = (page == 1) ? m_diag[m_ptr[page]] : id_mem[m_ptr[page]];
            chk(v == e, {tag, " read data"}, v, e);
            m_ptr[page] = (m_ptr[page] + 1) % 256;
        end
        bus_stop;
    endtask

    task automatic t_read_cur(input int page, input int n, input string tag);
        bus_start;
        rd_body(page, n, tag);
    endtask

    task automatic t_read_rand(input int page, input logic [7:0] a, input int n, input string tag);
        logic ack;
        bus_start;
        write_byte(dev_byte(page, 1'b0), ack); chk(ack, {tag, " device ack"}, ack, 1);
        write_byte(a, ack);                    chk(ack, {tag, " address ack"}, ack, 1);
        m_ptr[page] = a;
        bus_start;
        rd_body(page, n, tag);
    endtask

    initial begin
        logic ack, b;
        logic [7:0] v;
        scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            id_mem[i]   = 8'(i * 37 + 11);
            diag_mem[i] = 8'(i) ^ 8'h5A;
            m_diag[i]   = 8'(i) ^ 8'h5A;
        end
        m_ptr[0] = 0; m_ptr[1] = 0;

        // R11 reset state
        cycles(6);
        chk(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
        chk(diag_we == 1'b0, "R11 no strobe in reset", diag_we, 0);
        chk(id_addr == 8'd0 && diag_addr == 8'd0, "R11 pointers cleared", {id_addr, diag_addr}, 0);
        rst_n = 1'b1;
        cycles(20);

        // R2 and R4: diagnostic write burst, then random sequential read
        wq = {8'hA1, 8'hB2, 8'hC3};
        t_write(1, 8'h80, "R2");
        t_read_rand(1, 8'h80, 3, "R4");

        // R8: window edges at 128 and 247, and a low address
        wq = {8'h11, 8'h22, 8'h33};
        t_write(1, 8'd126, "R8 low edge");
        t_read_rand(1, 8'd126, 3, "R8 low edge");
        wq = {8'h44, 8'h55, 8'h66};
        t_write(1, 8'd246, "R8 high edge");
        t_read_rand(1, 8'd246, 3, "R8 high edge");
        wq = {8'h77};
        t_write(1, 8'd5, "R8 below window");
        t_read_rand(1, 8'd5, 1, "R8 below window");

        // R1 and R7: identity page writes are discarded, pointer advances
        wq = {8'h99, 8'h98};
        t_write(0, 8'h10, "R1 R7");
        t_read_cur(0, 2, "R7 pointer advanced");
        t_read_rand(0, 8'h10, 2, "R7 contents unchanged");

        // R5: wrap on both pages
        t_read_rand(0, 8'hFE, 4, "R5 identity wrap");
        wq = {8'hEE, 8'hDD};
        t_write(1, 8'hFF, "R5 diag wrap");
        t_read_cur(1, 1, "R5 diag wrap");

        // R6: independent pointers
        wq = {};
        t_write(0, 8'h30, "R6 set identity pointer");
        t_write(1, 8'h90, "R6 set diag pointer");
        t_read_cur(0, 1, "R6 identity current");
        t_read_cur(1, 2, "R6 diag current");
        t_read_cur(0, 1, "R6 identity again");

        // R10: glitches on both lines during a data byte
        bus_start;
        write_byte(dev_byte(1, 1'b0), ack); chk(ack, "R10 device ack", ack, 1);
        write_byte(8'hA0, ack);             chk(ack, "R10 address ack", ack, 1);
        v = 8'hB5;
        for (int i = 7; i >= 0; i--) send_bit_glitch(v[i]);
        recv_bit(b); chk(!b, "R10 data ack", !b, 1);
        bus_stop;
        m_diag[8'hA0] = 8'hB5; m_ptr[1] = 8'hA1;
        t_read_rand(1, 8'hA0, 1, "R10 glitch-free data");

        // R3: foreign address, repeated START ignored until STOP
        quiet = 1'b1;
        bus_start;
        write_byte(8'hA4, ack); chk(!ack, "R3 foreign address nack", ack, 0);
        bus_start;
        write_byte(8'hA0, ack); chk(!ack, "R3 repeated start ignored", ack, 0);
        bus_stop;
        quiet = 1'b0;
        chk(quiet_viol == 0, "R3 sda stayed released", quiet_viol, 0);
        t_read_cur(0, 1, "R3 pointer untouched");

        // R9: master NACK, then stray clocks before STOP
        bus_start;
        write_byte(dev_byte(1, 1'b1), ack); chk(ack, "R9 device ack", ack, 1);
        read_byte(v, 1'b0);
        chk(v == m_diag[m_ptr[1]], "R9 read data", v, m_diag[m_ptr[1]]);
        m_ptr[1] = (m_ptr[1] + 1) % 256;
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            recv_bit(b);
            chk(b == 1'b1, "R9 bus left released", b, 1);
        end
        bus_stop;
        quiet = 1'b0;
        chk(quiet_viol == 0, "R9 no drive after nack", quiet_viol, 0);
        t_read_cur(1, 1, "R9 pointer after nack");

        // R8 and R11: whole diagnostic page against the model
        for (int i = 0; i < 256; i++)
            if (diag_mem[i] != m_diag[i])
                chk(1'b0, "R8 page image", diag_mem[i], m_diag[i]);
        chk(1'b1, "R8 page image compared", 0, 0);

        // R12: drive changes only with SCL low, over the whole run
        chk(r12_viol == 0, "R12 drive changed with SCL high", r12_viol, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule